// File: doc/BRIEF.md
# Dual Serial Shift Register with Clock-OR Stepping

This block holds two independent 8-stage serial-in shift registers, called lane A and lane B. Each lane has two clock inputs, a shared one (`com_clk`) and its own (`a_clk` or `b_clk`). A lane steps when the OR of those two inputs rises. Because a step needs that rise, holding either input high keeps the lane frozen. The other input then acts as nothing more than a clock that is being inhibited.

Every lane input is sampled on the free-running system clock `clk`, so the whole block stays synchronous. A lane steps in the system cycle where its OR'd clock reads 1 after reading 0 in the cycle before. The new stage-0 bit comes from a two-way data multiplexer that is steered by the lane's select line. The last stage of each lane is brought out, and so is the full stage vector.

An active-low clear (`clear_n`) empties both lanes at once, without waiting for `clk`. It also wipes each lane's record of its previous OR'd clock value.

Top module: `dsr_dual`

## Requirements
- R1: The two lanes are independent. Each has its own clock input, select, and two data inputs, and a step of one lane never changes the other lane's stages.
- R2: A lane's effective clock is `com_clk` OR its own clock input, so a rise on either input alone can step the lane.
- R3: A lane steps exactly once in the `clk` cycle where its OR'd clock is sampled 1 and was sampled 0 in the previous cycle. This also applies when both inputs rise in the same cycle.
- R4: While the OR'd clock of a lane stays high, the lane keeps its stages. With one clock input held at 1, toggling the other input causes no step.
- R5: On a step, stage 0 takes `d1` when the lane's select is 1 and `d0` when it is 0, using the values sampled in that cycle.
- R6: On a step, stage i takes the old stage i-1 for i = 1..7. Bit i of the `*_stages` output is stage i, and `*_q7` equals stage 7, so a bit taken in appears on `*_q7` after eight steps.
- R7: While `clear_n` is 0, all 16 stages read 0. The clear takes effect without waiting for a `clk` edge.
- R8: The clear also sets each lane's stored previous OR'd clock to 0. If a lane's OR'd clock is 1 in the first cycle after `clear_n` returns to 1, that cycle counts as a rising edge and the lane steps once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock on which all inputs are sampled |
| clear_n | input | 1 | Asynchronous active-low clear of both lanes and their edge history |
| com_clk | input | 1 | Clock input shared by both lanes |
| a_clk | input | 1 | Lane A's own clock input |
| a_sel | input | 1 | Lane A select: 0 takes `a_d0`, 1 takes `a_d1` |
| a_d0 | input | 1 | Lane A serial source 0 |
| a_d1 | input | 1 | Lane A serial source 1 |
| b_clk | input | 1 | Lane B's own clock input |
| b_sel | input | 1 | Lane B select: 0 takes `b_d0`, 1 takes `b_d1` |
| b_d0 | input | 1 | Lane B serial source 0 |
| b_d1 | input | 1 | Lane B serial source 1 |
| a_q7 | output | 1 | Lane A last stage |
| b_q7 | output | 1 | Lane B last stage |
| a_stages | output | 8 | Lane A stages, bit i = stage i |
| b_stages | output | 8 | Lane B stages, bit i = stage i |

## Verification
The hardest case to produce from the ports is a clear released while a lane's OR'd clock is already high, because it is the only way a lane steps without its clock inputs changing. The stimulus holds `com_clk` and `a_clk` high throughout the clear and lets it go on a falling edge of `clk`. It then checks that exactly one step follows and that the held clocks keep the lane frozen after that. A second clear is dropped between two `clk` edges, and the stages are sampled before the next edge to confirm that the clear does not wait for `clk`. Long random runs follow, mixing held clocks, single-input rises and rises on both inputs together.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int unsigned DSR_WIDTH = 8;
    localparam int unsigned DSR_LANES = 2;

    // per-lane input bundle sampled on the system clock
    typedef struct packed {
        logic own_clk;
        logic sel;
        logic d0;
        logic d1;
    } lane_in_t;

    // two-way serial source choice
    function automatic logic pick_serial(lane_in_t li);
        return li.sel ? li.d1 : li.d0;
    endfunction

endpackage

// File: rtl/dsr_edge.sv
module dsr_edge (
    input  logic clk,
    input  logic clear_n,
    input  logic com_clk,
    input  logic own_clk,
    output logic step
);
    logic or_now;
    logic prev_q;
    logic seen_q;

    assign or_now = com_clk | own_clk;

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= or_now;
            seen_q <= 1'b1;
        end
    end

    assign step = or_now & ~prev_q;

    // R3: a fresh rise of the OR'd clock steps the lane
    assert_edge_R3: assert property (@(posedge clk) disable iff (!clear_n)
        (seen_q && or_now && !$past(or_now)) |-> step);

    // R4: an OR'd clock already high in the previous cycle never steps
    assert_inhibit_R4: assert property (@(posedge clk) disable iff (!clear_n)
        (seen_q && $past(or_now)) |-> !step);

    // R8: first cycle after clear with the OR'd clock high is a rise
    assert_release_R8: assert property (@(posedge clk) disable iff (!clear_n)
        (!seen_q && or_now) |-> step);

endmodule

// File: rtl/dsr_lane.sv
module dsr_lane
    import dsr_pkg::*;
#(
    parameter int unsigned WIDTH = DSR_WIDTH
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             step,
    input  lane_in_t         lin,
    output logic [WIDTH-1:0] stages
);
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            stages <= '0;
        end else if (step) begin
            stages <= {stages[WIDTH-2:0], pick_serial(lin)};
        end
    end

    // R5: stage 0 takes the selected source sampled on the step
    assert_stage0_R5: assert property (@(posedge clk) disable iff (!clear_n)
        step |=> (stages[0] == ($past(lin.sel) ? $past(lin.d1) : $past(lin.d0))));

    // R6: each higher stage takes its lower neighbour
    assert_shift_R6: assert property (@(posedge clk) disable iff (!clear_n)
        step |=> (stages[WIDTH-1:1] == $past(stages[WIDTH-2:0])));

    // R4: no step, no change
    assert_hold_R4: assert property (@(posedge clk) disable iff (!clear_n)
        !step |=> $stable(stages));

endmodule

// File: rtl/dsr_dual.sv
module dsr_dual
    import dsr_pkg::*;
#(
    parameter int unsigned WIDTH = DSR_WIDTH
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             com_clk,
    input  logic             a_clk,
    input  logic             a_sel,
    input  logic             a_d0,
    input  logic             a_d1,
    input  logic             b_clk,
    input  logic             b_sel,
    input  logic             b_d0,
    input  logic             b_d1,
    output logic             a_q7,
    output logic             b_q7,
    output logic [WIDTH-1:0] a_stages,
    output logic [WIDTH-1:0] b_stages
);
    localparam int unsigned LANES = DSR_LANES;

    lane_in_t         lin  [LANES];
    logic             step [LANES];
    logic [WIDTH-1:0] st   [LANES];

    assign lin[0] = {a_clk, a_sel, a_d0, a_d1};
    assign lin[1] = {b_clk, b_sel, b_d0, b_d1};

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            dsr_edge u_edge (
                .clk     (clk),
                .clear_n (clear_n),
                .com_clk (com_clk),
                .own_clk (lin[g].own_clk),
                .step    (step[g])
            );
            dsr_lane #(.WIDTH(WIDTH)) u_lane (
                .clk     (clk),
                .clear_n (clear_n),
                .step    (step[g]),
                .lin     (lin[g]),
                .stages  (st[g])
            );
        end
    endgenerate

    assign a_stages = st[0];
    assign b_stages = st[1];
    assign a_q7     = st[0][WIDTH-1];
    assign b_q7     = st[1][WIDTH-1];

    // R7: clear holds every stage at zero
    assert_clear_R7: assert property (@(posedge clk)
        !clear_n |-> (a_stages == '0 && b_stages == '0));

    // R1: a lane whose own clock and the shared clock stay low keeps its stages
    assert_indep_R1: assert property (@(posedge clk) disable iff (!clear_n)
        (!com_clk && !b_clk) |=> $stable(b_stages));

endmodule

// File: tb/sim_dsr_dual.sv
`timescale 1ns/1ps
module sim_dsr_dual;
    logic clk = 1'b0;
    logic clear_n = 1'b0;
    logic com_clk = 1'b0;
    logic a_clk = 1'b0, a_sel = 1'b0, a_d0 = 1'b0, a_d1 = 1'b0;
    logic b_clk = 1'b0, b_sel = 1'b0, b_d0 = 1'b0, b_d1 = 1'b0;
    logic a_q7, b_q7;
    logic [7:0] a_stages, b_stages;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dsr_dual u0 (
        .clk(clk), .clear_n(clear_n), .com_clk(com_clk),
        .a_clk(a_clk), .a_sel(a_sel), .a_d0(a_d0), .a_d1(a_d1),
        .b_clk(b_clk), .b_sel(b_sel), .b_d0(b_d0), .b_d1(b_d1),
        .a_q7(a_q7), .b_q7(b_q7), .a_stages(a_stages), .b_stages(b_stages)
    );

    // behavioural reference: newest bit at the queue front
    bit qa[$];
    bit qb[$];
    int prev_a = 0;
    int prev_b = 0;

    task automatic model_clear();
        qa.delete(); qb.delete();
        for (int i = 0; i < 8; i++) begin qa.push_back(1'b0); qb.push_back(1'b0); end
        prev_a = 0; prev_b = 0;
    endtask

    function automatic logic [7:0] qvec(bit q[$]);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = q[i];
        return v;
    endfunction

    always @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            model_clear();
        end else begin
            int ora;
            int orb;
            bit dump;
            ora = (com_clk | a_clk) ? 1 : 0;
            orb = (com_clk | b_clk) ? 1 : 0;
            if (ora == 1 && prev_a == 0) begin
                qa.push_front(a_sel ? a_d1 : a_d0);
                dump = qa.pop_back();
            end
            if (orb == 1 && prev_b == 0) begin
                qb.push_front(b_sel ? b_d1 : b_d0);
                dump = qb.pop_back();
            end
            prev_a = ora;
            prev_b = orb;
        end
    end

    task automatic check_all(string req);
        logic [7:0] ea, eb;
        ea = qvec(qa);
        eb = qvec(qb);
        compared++;
        if (a_stages !== ea || a_q7 !== ea[7]) begin
            mismatched++;
            $display("FAIL %s lane A: actual %b/%b expected %b/%b", req, a_stages, a_q7, ea, ea[7]);
        end
        compared++;
        if (b_stages !== eb || b_q7 !== eb[7]) begin
            mismatched++;
            $display("FAIL %s lane B: actual %b/%b expected %b/%b", req, b_stages, b_q7, eb, eb[7]);
        end
    endtask

    task automatic tick(string req);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic expect_vec(string req, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        model_clear();
        // R7 / R8: clear held with clocks high
        com_clk = 1'b1; a_clk = 1'b1; a_sel = 1'b1; a_d1 = 1'b1;
        repeat (3) tick("R7 reset state");
        expect_vec("R7 reset A", a_stages, 8'h00);
        expect_vec("R7 reset B", b_stages, 8'h00);
        clear_n = 1'b1;                     // released on a falling edge
        tick("R8 release step");
        expect_vec("R8 one step on release A", a_stages, 8'h01);
        expect_vec("R8 one step on release B", b_stages, 8'h00);
        // R4: one input held high inhibits the other
        for (int i = 0; i < 6; i++) begin
            a_clk = ~a_clk;
            tick("R4 inhibit");
        end
        expect_vec("R4 held clock keeps A", a_stages, 8'h01);
        // R2 / R1: own clock alone steps lane A only
        com_clk = 1'b0; a_clk = 1'b0;
        tick("R2 settle");
        a_sel = 1'b0; a_d0 = 1'b0; a_d1 = 1'b1;
        a_clk = 1'b1; tick("R2 own clock rise");
        a_clk = 1'b0; tick("R1 idle");
        expect_vec("R1 lane B untouched", b_stages, 8'h01 & 8'h00);
        expect_vec("R5 sel0 takes d0", a_stages, 8'h02);
        // R6: a single 1 walks to q7 after eight steps
        clear_n = 1'b0; tick("R7 clear");
        clear_n = 1'b1; tick("R7 release");
        for (int i = 0; i < 8; i++) begin
            b_sel = 1'b1; b_d1 = (i == 0); b_d0 = 1'b1;
            b_clk = 1'b1; tick("R6 walk");
            b_clk = 1'b0; tick("R6 walk");
        end
        compared++;
        if (b_q7 !== 1'b1 || b_stages !== 8'h80) begin
            mismatched++;
            $display("FAIL R6 q7 after eight steps: actual %b expected %b", b_stages, 8'h80);
        end
        // R3: both inputs rise together, one step only
        b_sel = 1'b0; b_d0 = 1'b1;
        com_clk = 1'b1; b_clk = 1'b1; tick("R3 joint rise");
        expect_vec("R3 joint rise single step", b_stages, 8'h01);
        com_clk = 1'b0; b_clk = 1'b0; tick("R3 fall");
        // R7: asynchronous clear between edges
        #1 clear_n = 1'b0;
        #0.5;
        expect_vec("R7 async clear A", a_stages, 8'h00);
        expect_vec("R7 async clear B", b_stages, 8'h00);
        tick("R7 during clear");
        clear_n = 1'b1;
        // random mix of everything
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) com_clk = ~com_clk;
            if ($urandom_range(0, 2) == 0) a_clk = ~a_clk;
            if ($urandom_range(0, 2) == 0) b_clk = ~b_clk;
            a_sel = 1'($urandom); a_d0 = 1'($urandom); a_d1 = 1'($urandom);
            b_sel = 1'($urandom); b_d0 = 1'($urandom); b_d1 = 1'($urandom);
            if ($urandom_range(0, 499) == 0) clear_n = 1'b0;
            else clear_n = 1'b1;
            tick("R1-mix R3 R5 R6 random");
        end
        finish_run();
    end
endmodule